// File: doc/BRIEF.md
# Register-Mapped Fixed-Point Adder Wrapper

This block places a small fixed-point compute kernel behind an AXI4-Lite slave port so that a processor can drive it. Software writes two unsigned 16-bit operands in Q1.15 form into input registers. It reads the kernel result, an unsigned 16-bit Q2.14 value, from a result register. A control word gates the kernel, and writing a set bit to a reset word issues a one-cycle internal reset. A read-only word returns a build stamp that was fixed when the block was built.

The block runs free. The software and the kernel do not synchronise. A value written to an operand register reaches the kernel at once, and the result register always holds the newest result the kernel has produced. The placeholder kernel adds the two operands and rescales the sum to the output format. The writable registers do not read back: a read of any of them returns zero.

Top module: `axil_kernel_wrap`

## Requirements
- R1: A write completes only after both its address and its data are accepted, and they may come in either order or together. Each write gives exactly one write response with bresp = 0 (OKAY). bvalid stays high until bready is seen.
- R2: Each accepted read address gives exactly one read response with rresp = 0. rvalid and rdata hold steady until rready is seen. arready is low while a read response is pending.
- R3: The word at offset 0x008 reads as the build stamp 0x7D5A7ABB (decimal 2103081659). Writes to it are ignored.
- R4: Offset 0x100 holds operand A and offset 0x104 holds operand B. wstrb[0] writes bits 7:0, wstrb[1] writes bits 15:8, and wdata bits 31:16 are ignored.
- R5: Offset 0x108 returns the result floor((A+B)/2) in bits 15:0, with bits 31:16 at zero. The result updates one clock after an operand changes while the kernel is enabled. Writes to 0x108 are ignored.
- R6: Reads of 0x000, 0x004, 0x100, 0x104 and of any unmapped word return 0 with rresp = 0. Address bits 1:0 are ignored.
- R7: Bit 0 of offset 0x004, written under wstrb[0], enables the kernel, and its reset value is 1. While it is 0, the result holds its value.
- R8: A write to offset 0x000 with bit 0 = 1 and wstrb[0] set creates a one-cycle internal reset. That reset clears A, B and the result and sets the enable back to 1. A write with bit 0 = 0 has no effect, and the bus channels are never reset by it.
- R9: After the external reset, bvalid and rvalid are low, awready, wready and arready are high, the result is 0 and the kernel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |

## Verification
The assertions assume a master that keeps to the AXI4-Lite protocol. A master keeps its own valid signals high until the matching handshake and never asks for a second write response before it has taken the first. The bench drives every channel from tasks that keep a valid high until it sees ready at a falling edge and then drop it. Those tasks vary the address/data order and the response back-pressure at random, and they never start a new transaction while a response is still outstanding. The hold-while-disabled property takes for granted that the internal reset is the only thing that moves the result while the enable is low. The soft-reset properties take for granted that the bus reset stays high around the pulse, and the stimulus only pulses the soft reset well after the external reset has been released.

// File: rtl/axk_pkg.sv
// Package axk_pkg
// Holds the register offsets and the build stamp of the adder wrapper.
// Assumes 32-bit words aligned on 4-byte boundaries.
package axk_pkg;
    localparam int unsigned OFF_SOFTRST = 32'h000;
    localparam int unsigned OFF_ENABLE  = 32'h004;
    localparam int unsigned OFF_STAMP   = 32'h008;
    localparam int unsigned OFF_OPND_A  = 32'h100;
    localparam int unsigned OFF_OPND_B  = 32'h104;
    localparam int unsigned OFF_RESULT  = 32'h108;

    localparam logic [31:0] BUILD_STAMP = 32'd2103081659;

    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/axk_wr_port.sv
// Module axk_wr_port
// Accepts one write address and one write data beat, in either order or
// together. When both are held it issues a single commit strobe, then keeps
// the write response up until the master takes it. Assumes the master does
// not drop its valid signals before the handshake.
module axk_wr_port #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  awvalid,
    output logic                  awready,
    input  logic [ADDR_W-1:0]     awaddr,
    input  logic                  wvalid,
    output logic                  wready,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W/8-1:0]   wstrb,
    output logic                  bvalid,
    input  logic                  bready,
    output logic [1:0]            bresp,
    output logic                  wr_en,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W/8-1:0]   wr_strb
);
    import axk_pkg::*;

    logic aw_full;
    logic w_full;

    assign awready = !aw_full;
    assign wready  = !w_full;
    assign wr_en   = aw_full && w_full && !bvalid;
    assign bresp   = RESP_OKAY;

    // Capture the write address and hold it until the commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_full <= 1'b0;
            wr_addr <= '0;
        end else if (awvalid && awready) begin
            aw_full <= 1'b1;
            wr_addr <= awaddr;
        end else if (wr_en) begin
            aw_full <= 1'b0;
        end
    end

    // Capture the write data and strobes and hold them until the commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_full  <= 1'b0;
            wr_data <= '0;
            wr_strb <= '0;
        end else if (wvalid && wready) begin
            w_full  <= 1'b1;
            wr_data <= wdata;
            wr_strb <= wstrb;
        end else if (wr_en) begin
            w_full <= 1'b0;
        end
    end

    // Raise the response on commit and drop it once the master takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)       bvalid <= 1'b0;
        else if (wr_en)   bvalid <= 1'b1;
        else if (bready)  bvalid <= 1'b0;
    end

    assert_bvalid_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);

    assert_commit_gives_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bvalid && !aw_full && !w_full);
endmodule

// File: rtl/axk_rd_port.sv
// Module axk_rd_port
// Serves one read at a time. On the address handshake it latches the value
// the decoder returns for the offered address, then holds the response
// until the master takes it. Assumes the decoder output is combinational
// in rd_addr.
module axk_rd_port #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_val
);
    import axk_pkg::*;

    assign arready = !rvalid;
    assign rd_addr = araddr;
    assign rresp   = RESP_OKAY;

    // Latch the decoded word on accept and release it on rready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (arvalid && arready) begin
            rvalid <= 1'b1;
            rdata  <= rd_val;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

    assert_rvalid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));

    assert_accept_gives_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && arready |=> rvalid);
endmodule

// File: rtl/axk_kernel.sv
// Module axk_kernel
// Placeholder compute kernel. It adds two unsigned Q1.15 operands and
// registers the sum rescaled to Q2.14, dropping the lowest bit. The result
// holds while en is low. rst_n here is the combined core reset.
module axk_kernel #(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SMP_W-1:0] in_a,
    input  logic [SMP_W-1:0] in_b,
    output logic [SMP_W-1:0] res
);
    localparam int SUM_W = SMP_W + 1;

    logic [SUM_W-1:0] sum;
    logic             unused_lsb;

    assign sum        = {1'b0, in_a} + {1'b0, in_b};
    assign unused_lsb = sum[0];

    // Register the rescaled sum whenever the kernel is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)   res <= '0;
        else if (en)  res <= sum[SUM_W-1:1];
    end

    assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(res));
endmodule

// File: rtl/axil_kernel_wrap.sv
// Module axil_kernel_wrap
// AXI4-Lite slave wrapper around axk_kernel. It decodes word offsets, keeps
// the two operand registers and the enable, makes a one-cycle soft reset
// pulse, and returns the stamp and the result on reads. Writable registers
// read as zero. Assumes DATA_W is 32 and SMP_W is a multiple of 8.
module axil_kernel_wrap #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int SMP_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_wvalid,
    output logic                s_wready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    output logic                s_bvalid,
    input  logic                s_bready,
    output logic [1:0]          s_bresp,
    input  logic                s_arvalid,
    output logic                s_arready,
    input  logic [ADDR_W-1:0]   s_araddr,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic [DATA_W-1:0]   s_rdata,
    output logic [1:0]          s_rresp
);
    import axk_pkg::*;

    localparam int STRB_W = DATA_W / 8;
    localparam int LANES  = SMP_W / 8;
    localparam int WORD_W = ADDR_W - 2;

    localparam logic [WORD_W-1:0] W_SOFTRST = WORD_W'(OFF_SOFTRST >> 2);
    localparam logic [WORD_W-1:0] W_ENABLE  = WORD_W'(OFF_ENABLE  >> 2);
    localparam logic [WORD_W-1:0] W_STAMP   = WORD_W'(OFF_STAMP   >> 2);
    localparam logic [WORD_W-1:0] W_OPND_A  = WORD_W'(OFF_OPND_A  >> 2);
    localparam logic [WORD_W-1:0] W_OPND_B  = WORD_W'(OFF_OPND_B  >> 2);
    localparam logic [WORD_W-1:0] W_RESULT  = WORD_W'(OFF_RESULT  >> 2);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [STRB_W-1:0] wr_strb;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_val;

    logic [SMP_W-1:0]  opnd_a_q;
    logic [SMP_W-1:0]  opnd_b_q;
    logic [SMP_W-1:0]  result;
    logic              en_q;
    logic              soft_q;
    logic              core_rst_n;

    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_word;
    logic              sel_rst;
    logic              sel_en;
    logic              sel_a;
    logic              sel_b;
    logic              unused_bits;

    axk_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .awaddr  (s_awaddr),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .bresp   (s_bresp),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_strb (wr_strb)
    );

    axk_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .araddr  (s_araddr),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .rdata   (s_rdata),
        .rresp   (s_rresp),
        .rd_addr (rd_addr),
        .rd_val  (rd_val)
    );

    axk_kernel #(.SMP_W(SMP_W)) u_kernel (
        .clk   (clk),
        .rst_n (core_rst_n),
        .en    (en_q),
        .in_a  (opnd_a_q),
        .in_b  (opnd_b_q),
        .res   (result)
    );

    assign wr_word    = wr_addr[ADDR_W-1:2];
    assign rd_word    = rd_addr[ADDR_W-1:2];
    assign sel_rst    = wr_en && (wr_word == W_SOFTRST);
    assign sel_en     = wr_en && (wr_word == W_ENABLE);
    assign sel_a      = wr_en && (wr_word == W_OPND_A);
    assign sel_b      = wr_en && (wr_word == W_OPND_B);
    assign core_rst_n = rst_n && !soft_q;
    assign unused_bits = ^{wr_addr[1:0], rd_addr[1:0], wr_data[DATA_W-1:SMP_W],
                           wr_strb[STRB_W-1:LANES]};

    // Make the self-clearing soft reset pulse from a write of bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_q <= 1'b0;
        else        soft_q <= sel_rst && wr_strb[0] && wr_data[0];
    end

    // Hold the kernel enable, which comes out of reset set.
    always_ff @(posedge clk) begin
        if (!core_rst_n)              en_q <= 1'b1;
        else if (sel_en && wr_strb[0]) en_q <= wr_data[0];
    end

    // Update the operand registers one byte lane at a time.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            opnd_a_q <= '0;
            opnd_b_q <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (sel_a && wr_strb[l]) opnd_a_q[l*8 +: 8] <= wr_data[l*8 +: 8];
                if (sel_b && wr_strb[l]) opnd_b_q[l*8 +: 8] <= wr_data[l*8 +: 8];
            end
        end
    end

    // Pick the read word. Writable and unmapped words return zero.
    always_comb begin
        rd_val = '0;
        if (rd_word == W_STAMP)       rd_val = DATA_W'(BUILD_STAMP);
        else if (rd_word == W_RESULT) rd_val = DATA_W'(result);
    end

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q |=> !soft_q);

    assert_pulse_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_q |=> en_q && opnd_a_q == '0 && opnd_b_q == '0 && result == '0);
endmodule

// File: tb/axil_kernel_wrap_bench.sv
module axil_kernel_wrap_bench;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam logic [31:0] STAMP = 32'h7D5A7ABB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              s_awvalid = 1'b0;
    logic              s_awready;
    logic [ADDR_W-1:0] s_awaddr = '0;
    logic              s_wvalid = 1'b0;
    logic              s_wready;
    logic [DATA_W-1:0] s_wdata = '0;
    logic [3:0]        s_wstrb = '0;
    logic              s_bvalid;
    logic              s_bready = 1'b0;
    logic [1:0]        s_bresp;
    logic              s_arvalid = 1'b0;
    logic              s_arready;
    logic [ADDR_W-1:0] s_araddr = '0;
    logic              s_rvalid;
    logic              s_rready = 1'b0;
    logic [DATA_W-1:0] s_rdata;
    logic [1:0]        s_rresp;

    int n_run  = 0;
    int n_fail = 0;

    logic [15:0] a_m = '0;
    logic [15:0] b_m = '0;
    logic [15:0] r_m = '0;
    logic        en_m = 1'b1;

    always #4 clk = ~clk;

    axil_kernel_wrap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SMP_W(16)) u_axil_kernel_wrap (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp)
    );

    function automatic logic [15:0] kern(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s = {1'b0, a} + {1'b0, b};
        return s[16:1];
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] d,
                                          input logic [3:0] strb);
        logic [15:0] n = old;
        if (strb[0]) n[7:0]  = d[7:0];
        if (strb[1]) n[15:8] = d[15:8];
        return n;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic axi_wr(input logic [11:0] addr, input logic [31:0] data,
                          input logic [3:0] strb, input int mode, input int bwait);
        bit aw_p = 1'b1;
        bit w_p  = 1'b1;
        bit aw_f;
        bit w_f;
        bit early = 1'b0;
        bit held  = 1'b1;
        int cyc = 0;
        s_awaddr = addr;
        s_wdata  = data;
        s_wstrb  = strb;
        while (aw_p || w_p) begin
            s_awvalid = aw_p && (mode != 2 || cyc >= 2);
            s_wvalid  = w_p  && (mode != 1 || cyc >= 2);
            aw_f = s_awvalid && s_awready;
            w_f  = s_wvalid && s_wready;
            early |= s_bvalid;
            @(negedge clk);
            cyc++;
            if (aw_f) aw_p = 1'b0;
            if (w_f)  w_p  = 1'b0;
        end
        s_awvalid = 1'b0;
        s_wvalid  = 1'b0;
        // R1: no response before both halves are in
        chk("R1", "early bvalid", {31'd0, early}, 32'd0);
        while (!s_bvalid) @(negedge clk);
        repeat (bwait) begin
            @(negedge clk);
            if (!s_bvalid) held = 1'b0;
        end
        chk("R1", "bvalid held", {31'd0, held}, 32'd1);
        chk("R1", "bresp", {30'd0, s_bresp}, 32'd0);
        s_bready = 1'b1;
        @(negedge clk);
        s_bready = 1'b0;
        chk("R1", "bvalid dropped", {31'd0, s_bvalid}, 32'd0);
    endtask

    task automatic axi_rd(input logic [11:0] addr, input int rwait, output logic [31:0] data);
        logic [31:0] first;
        bit held = 1'b1;
        s_araddr  = addr;
        s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        first = s_rdata;
        if (!s_rvalid) held = 1'b0;
        repeat (rwait) begin
            @(negedge clk);
            if (!s_rvalid || s_rdata !== first || s_arready) held = 1'b0;
        end
        chk("R2", "rvalid/rdata held", {31'd0, held}, 32'd1);
        chk("R2", "rresp", {30'd0, s_rresp}, 32'd0);
        data = s_rdata;
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    task automatic wr_model(input logic [11:0] addr, input logic [31:0] data, input logic [3:0] strb);
        axi_wr(addr, data, strb, int'($urandom % 3), int'($urandom % 3));
        case (addr[11:2])
            10'h000: if (strb[0] && data[0]) begin a_m = '0; b_m = '0; r_m = '0; en_m = 1'b1; end
            10'h001: if (strb[0]) en_m = data[0];
            10'h040: a_m = merge(a_m, data, strb);
            10'h041: b_m = merge(b_m, data, strb);
            default: ;
        endcase
        if (en_m) r_m = kern(a_m, b_m);
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [11:0] addr, input string req, input logic [31:0] exp);
        logic [31:0] d;
        axi_rd(addr, int'($urandom % 3), d);
        chk(req, $sformatf("read 0x%03h", addr), d, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9", "bvalid", {31'd0, s_bvalid}, 32'd0);
        chk("R9", "rvalid", {31'd0, s_rvalid}, 32'd0);
        chk("R9", "readies", {29'd0, s_awready, s_wready, s_arready}, 32'd7);
        rd_chk(12'h108, "R9", 32'd0);

        // R4 R5: operands in different write orders
        axi_wr(12'h100, 32'h0000_8000, 4'hF, 0, 0); a_m = 16'h8000;
        axi_wr(12'h104, 32'hABCD_4000, 4'hF, 1, 2); b_m = 16'h4000;
        rd_chk(12'h108, "R5", 32'h0000_6000);
        // R5: full-scale operands
        axi_wr(12'h100, 32'hFFFF_FFFF, 4'hF, 2, 1);
        axi_wr(12'h104, 32'h0000_FFFF, 4'h3, 0, 0);
        rd_chk(12'h108, "R5", 32'h0000_FFFF);
        // R4: byte strobes
        axi_wr(12'h100, 32'h0000_1234, 4'h1, 0, 0);
        axi_wr(12'h104, 32'h0000_5600, 4'h2, 1, 0);
        a_m = 16'hFF34; b_m = 16'h56FF; r_m = kern(a_m, b_m);
        rd_chk(12'h108, "R4", {16'd0, r_m});
        // R3: stamp, writes ignored; R5: result writes ignored
        rd_chk(12'h008, "R3", STAMP);
        axi_wr(12'h008, 32'h0, 4'hF, 0, 0);
        rd_chk(12'h00A, "R3", STAMP);
        axi_wr(12'h108, 32'h0, 4'hF, 0, 0);
        rd_chk(12'h108, "R5", {16'd0, r_m});
        // R6: writable and unmapped words read zero
        rd_chk(12'h100, "R6", 32'd0);
        rd_chk(12'h104, "R6", 32'd0);
        rd_chk(12'h004, "R6", 32'd0);
        rd_chk(12'h000, "R6", 32'd0);
        rd_chk(12'h20C, "R6", 32'd0);
        // R7: disable holds result, enable catches up
        wr_model(12'h004, 32'h0, 4'h1);
        wr_model(12'h100, 32'h0000_0002, 4'h3);
        rd_chk(12'h108, "R7", {16'd0, r_m});
        wr_model(12'h004, 32'h1, 4'h1);
        rd_chk(12'h108, "R7", {16'd0, r_m});
        // R8: writing 0 does nothing, writing 1 clears
        wr_model(12'h000, 32'hFFFF_FFFE, 4'hF);
        rd_chk(12'h108, "R8", {16'd0, r_m});
        wr_model(12'h004, 32'h0, 4'h1);
        wr_model(12'h000, 32'h1, 4'h1);
        rd_chk(12'h108, "R8", 32'd0);
        wr_model(12'h104, 32'h0000_0010, 4'h3);
        rd_chk(12'h108, "R8", 32'h0000_0008);

        // Random mix
        for (int i = 0; i < 120; i++) begin
            int op = int'($urandom % 8);
            case (op)
                0, 1: wr_model(12'h100, $urandom, 4'($urandom));
                2, 3: wr_model(12'h104, $urandom, 4'($urandom));
                4:    wr_model(12'h004, $urandom, 4'($urandom | 1));
                5:    rd_chk(12'h108, en_m ? "R5" : "R7", {16'd0, r_m});
                6: begin
                    int s = int'($urandom % 4);
                    if (s == 0)      rd_chk(12'h008, "R3", STAMP);
                    else if (s == 1) rd_chk(12'h104, "R6", 32'd0);
                    else if (s == 2) rd_chk(12'h3F0, "R6", 32'd0);
                    else             rd_chk(12'h004, "R6", 32'd0);
                end
                default: wr_model(12'h000, (($urandom % 4) == 0) ? 32'h1 : 32'h0, 4'hF);
            endcase
        end
        rd_chk(12'h108, "R5", {16'd0, r_m});

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule